// File: doc/BRIEF.md
# Striped Byte-Lane FIFO Pair with Interrupt Status

This block holds the data buffering for a serial master. It has one transmit and one receive store, and each is built from four parallel byte lanes with sixteen entries per lane. The host reaches a store through a 32-bit word port or an 8-bit byte port. A word access moves one byte in every lane at the same time, which gives 64 bytes of capacity. A byte access touches lane 0 only, which gives 16 bytes. The shift engine on the far side moves one byte per strobe. In word mode it steps round the lanes in a fixed order. In byte mode it stays on lane 0.

A status register collects level flags from both stores, a pulse-type illegal-access flag and a pulse-type transfer-finished flag. Each flag stays set until a write-one clear removes it. An enable register selects which flags drive a level-high interrupt line. The address decoding of these registers and the serializer are outside the block.

Top module: `stripe_fifo_pair`

## Requirements
- R1: While reset is asserted, the status and enable registers are zero, the interrupt is low and both stores are empty, so no transmit byte is offered.
- R2: A transmit word write puts byte k (bits 8k+7:8k) into lane k. In word mode the engine takes lane 0, then lanes 1, 2 and 3, and then wraps, so the bytes leave low byte first, word after word.
- R3: In byte mode the transmit byte port writes bits 7:0 into lane 0 and the engine reads only lane 0, first in first out, with room for 16 bytes.
- R4: In word mode the transmit store holds 16 words (64 bytes) before its full flag (bit 3) rises. Half-full (bit 2) rises at 32 bytes.
- R5: A write when the addressed lanes have no room, or a read when they hold no data, changes no stored byte and sets illegal-access (bit 12). The addressed lanes are any of the four for a word access and lane 0 for a byte access.
- R6: In word mode the engine fills the receive lanes 0 to 3 in rotation. Word-available (bit 6) is set only when every receive lane holds a byte. A receive word read returns lane k in byte k.
- R7: Byte-available (bit 11) follows whether receive lane 0 holds data. A receive byte read returns the head of lane 0 in bits 7:0, with the upper bits zero.
- R8: The level flags are transmit full (bit 3), half (bit 2), empty (bit 1) and trigger (bit 0, fill at or below TX_TRIG = 4). The receive level flags are full (bit 8), half (bit 7) and trigger (bit 5, fill at or above RX_TRIG = 8). Fill counts all lanes in word mode and lane 0 alone in byte mode. A flag is set in status two clock edges after the strobe that causes it.
- R9: A status bit stays set until it is cleared. Writing 1 to a clear bit makes it read 0 after the next edge. A level flag whose condition still holds sets again one edge later.
- R10: A transfer-finished pulse sets bit 9, which stays set until cleared and does not set again by itself.
- R11: The interrupt is high exactly when a status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1: engine rotates over all lanes; 0: engine uses lane 0 |
| host_tx_wr | input | 1 | Host transmit write strobe |
| host_tx_word | input | 1 | 1: word access, 0: byte access |
| host_tx_wdata | input | 32 | Host transmit data |
| host_rx_rd | input | 1 | Host receive read strobe |
| host_rx_word | input | 1 | 1: word access, 0: byte access |
| host_rx_rdata | output | 32 | Receive data at the head of the addressed lanes |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_valid | output | 1 | Current transmit lane holds a byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Current receive lane has room |
| eng_done | input | 1 | Transfer-finished pulse |
| irq_en_wr | input | 1 | Load the enable register |
| irq_en_wdata | input | 13 | New enable value |
| irq_clr_wr | input | 1 | Write-one-to-clear strobe |
| irq_clr_wdata | input | 13 | Bits to clear |
| irq_status | output | 13 | Latched status flags |
| irq | output | 1 | Level-high interrupt |

## Verification
Distinct transmit words are sent in word mode to show that the lane mapping and the engine order give low byte first, and that this order carries on across a word boundary. Sixteen-byte and sixty-four-byte fills are sent in each mode. These show the capacity of a single lane against all four lanes, and they show the half and full thresholds, with a value one below each threshold to catch an off-by-one error. Receive sequences of three and four bytes separate byte-available from word-available. A word read attempted too early shows that a rejected access leaves the data in place. Clear writes on idle flags, a done pulse and enable masks separate the re-setting level flags from the pulse flags, and show how the interrupt is gated.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    localparam int ST_W = 13;

    localparam int B_TX_TRIG  = 0;
    localparam int B_TX_EMPTY = 1;
    localparam int B_TX_HALF  = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_TRIG  = 5;
    localparam int B_RX_WORD  = 6;
    localparam int B_RX_HALF  = 7;
    localparam int B_RX_FULL  = 8;
    localparam int B_DONE     = 9;
    localparam int B_RX_BYTE  = 11;
    localparam int B_ILLEGAL  = 12;

    typedef struct packed {
        logic [ST_W-1:0] status;
        logic [ST_W-1:0] enable;
    } flag_regs_t;

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= push_data;
    end

    assign head  = mem[st_q.rp];
    assign count = st_q.cnt;

    // R5: the side logic never pushes into a full lane
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CW'(DEPTH)));

    // R5: the side logic never pops an empty lane
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

endmodule

// File: rtl/stripe_side.sv
module stripe_side #(
    parameter int LANES     = 4,
    parameter int DEPTH     = 16,
    parameter bit HOST_PUSH = 1'b1,
    parameter int IN_W      = HOST_PUSH ? LANES * 8 : 8,
    parameter int OUT_W     = HOST_PUSH ? 8 : LANES * 8,
    parameter int FW        = $clog2(LANES * DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_mode,
    input  logic             host_req,
    input  logic             host_word,
    input  logic             sh_req,
    input  logic [IN_W-1:0]  push_data,
    output logic [OUT_W-1:0] pop_data,
    output logic             sh_ok,
    output logic [FW-1:0]    fill,
    output logic [LANES-1:0] nonempty,
    output logic             host_bad
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } side_st_t;

    side_st_t st_d, st_q;

    logic [CW-1:0]    cnt      [LANES];
    logic [7:0]       head     [LANES];
    logic [7:0]       lane_din [LANES];
    logic [LANES-1:0] lane_push, lane_pop, lane_full;
    logic             host_ok, sh_fire;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign nonempty[g]  = (cnt[g] != '0);
        assign lane_full[g] = (cnt[g] == CW'(DEPTH));
        if (HOST_PUSH) begin : g_hp
            assign lane_push[g] = host_req && host_ok && (host_word || g == 0);
            assign lane_din[g]  = host_word ? push_data[8*g +: 8] : push_data[7:0];
            assign lane_pop[g]  = sh_fire && (st_q.ptr == PW'(g));
        end else begin : g_sp
            assign lane_push[g] = sh_fire && (st_q.ptr == PW'(g));
            assign lane_din[g]  = push_data;
            assign lane_pop[g]  = host_req && host_ok && (host_word || g == 0);
            assign pop_data[8*g +: 8] = (host_word || g == 0) ? head[g] : 8'h00;
        end
        lane_fifo #(.DEPTH(DEPTH), .W(8), .CW(CW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (lane_push[g]),
            .push_data (lane_din[g]),
            .pop       (lane_pop[g]),
            .head      (head[g]),
            .count     (cnt[g])
        );
    end

    if (HOST_PUSH) begin : g_tx_side
        assign host_ok  = host_word ? ~|lane_full : ~lane_full[0];
        assign sh_ok    = nonempty[st_q.ptr];
        assign pop_data = head[st_q.ptr];
    end else begin : g_rx_side
        assign host_ok = host_word ? &nonempty : nonempty[0];
        assign sh_ok   = ~lane_full[st_q.ptr];
    end

    assign sh_fire  = sh_req && sh_ok;
    assign host_bad = host_req && !host_ok;

    always_comb begin
        logic [FW-1:0] sum;
        st_d = st_q;
        if (!word_mode)
            st_d.ptr = '0;
        else if (sh_fire)
            st_d.ptr = (st_q.ptr == PW'(LANES - 1)) ? '0 : st_q.ptr + 1'b1;
        sum = '0;
        for (int k = 0; k < LANES; k++) sum = sum + FW'(cnt[k]);
        fill = word_mode ? sum : FW'(cnt[0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a rejected host access with no engine activity leaves the fill unchanged
    p_reject_keeps_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_bad && !sh_req && $stable(word_mode)) |=> $stable(fill));

endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import stripe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] cond,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_mask,
    input  logic            en_wr,
    input  logic [ST_W-1:0] en_data,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    flag_regs_t r_d, r_q;
    logic [ST_W-1:0] kill;

    always_comb begin
        r_d        = r_q;
        kill       = clr_wr ? clr_mask : '0;
        r_d.status = (r_q.status | cond) & ~kill;
        if (en_wr) r_d.enable = en_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = r_q.status;
    assign irq    = |(r_q.status & r_q.enable);

    // R9: a clear write wins over a new event in the same cycle
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[B_ILLEGAL]) |=> !status[B_ILLEGAL]);

    // R9: a set flag stays set until cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_ILLEGAL] && !(clr_wr && clr_mask[B_ILLEGAL])) |=> status[B_ILLEGAL]);

    // R10: a done pulse is latched on the next edge
    p_done_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond[B_DONE] && !(clr_wr && clr_mask[B_DONE])) |=> status[B_DONE]);

endmodule

// File: rtl/stripe_fifo_pair.sv
module stripe_fifo_pair
    import stripe_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DEPTH   = 16,
    parameter int TX_TRIG = 4,
    parameter int RX_TRIG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_mode,
    input  logic             host_tx_wr,
    input  logic             host_tx_word,
    input  logic [31:0]      host_tx_wdata,
    input  logic             host_rx_rd,
    input  logic             host_rx_word,
    output logic [31:0]      host_rx_rdata,
    input  logic             eng_tx_pop,
    output logic             eng_tx_valid,
    output logic [7:0]       eng_tx_byte,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_byte,
    output logic             eng_rx_ready,
    input  logic             eng_done,
    input  logic             irq_en_wr,
    input  logic [ST_W-1:0]  irq_en_wdata,
    input  logic             irq_clr_wr,
    input  logic [ST_W-1:0]  irq_clr_wdata,
    output logic [ST_W-1:0]  irq_status,
    output logic             irq
);
    localparam int FW = $clog2(LANES * DEPTH + 1);

    logic [FW-1:0]    tx_fill, rx_fill, cap;
    logic [LANES-1:0] tx_ne, rx_ne;
    logic             tx_bad, rx_bad;
    logic [ST_W-1:0]  cond;

    stripe_side #(.LANES(LANES), .DEPTH(DEPTH), .HOST_PUSH(1'b1), .FW(FW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (word_mode),
        .host_req  (host_tx_wr),
        .host_word (host_tx_word),
        .sh_req    (eng_tx_pop),
        .push_data (host_tx_wdata),
        .pop_data  (eng_tx_byte),
        .sh_ok     (eng_tx_valid),
        .fill      (tx_fill),
        .nonempty  (tx_ne),
        .host_bad  (tx_bad)
    );

    stripe_side #(.LANES(LANES), .DEPTH(DEPTH), .HOST_PUSH(1'b0), .FW(FW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (word_mode),
        .host_req  (host_rx_rd),
        .host_word (host_rx_word),
        .sh_req    (eng_rx_push),
        .push_data (eng_rx_byte),
        .pop_data  (host_rx_rdata),
        .sh_ok     (eng_rx_ready),
        .fill      (rx_fill),
        .nonempty  (rx_ne),
        .host_bad  (rx_bad)
    );

    always_comb begin
        cap  = word_mode ? FW'(LANES * DEPTH) : FW'(DEPTH);
        cond = '0;
        cond[B_TX_TRIG]  = tx_fill <= FW'(TX_TRIG);
        cond[B_TX_EMPTY] = word_mode ? ~|tx_ne : ~tx_ne[0];
        cond[B_TX_HALF]  = tx_fill >= (cap >> 1);
        cond[B_TX_FULL]  = tx_fill == cap;
        cond[B_RX_TRIG]  = rx_fill >= FW'(RX_TRIG);
        cond[B_RX_WORD]  = &rx_ne;
        cond[B_RX_HALF]  = rx_fill >= (cap >> 1);
        cond[B_RX_FULL]  = rx_fill == cap;
        cond[B_DONE]     = eng_done;
        cond[B_RX_BYTE]  = rx_ne[0];
        cond[B_ILLEGAL]  = tx_bad | rx_bad;
    end

    flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (cond),
        .clr_wr   (irq_clr_wr),
        .clr_mask (irq_clr_wdata),
        .en_wr    (irq_en_wr),
        .en_data  (irq_en_wdata),
        .status   (irq_status),
        .irq      (irq)
    );

    // R1: after reset nothing is offered to the engine until the host writes
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !eng_tx_valid);

endmodule

// File: tb/sim_stripe_fifo_pair.sv
module sim_stripe_fifo_pair;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0, rst_n = 1'b0, word_mode = 1'b0;
    logic        host_tx_wr = 1'b0, host_tx_word = 1'b0;
    logic [31:0] host_tx_wdata = '0;
    logic        host_rx_rd = 1'b0, host_rx_word = 1'b0;
    logic [31:0] host_rx_rdata;
    logic        eng_tx_pop = 1'b0, eng_tx_valid;
    logic [7:0]  eng_tx_byte;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_ready, eng_done = 1'b0;
    logic        irq_en_wr = 1'b0, irq_clr_wr = 1'b0;
    logic [12:0] irq_en_wdata = '0, irq_clr_wdata = '0;
    logic [12:0] irq_status;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    stripe_fifo_pair u0 (.*);

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic tx_write(input logic word, input logic [31:0] d);
        host_tx_wr = 1'b1; host_tx_word = word; host_tx_wdata = d;
        tick();
        host_tx_wr = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        chk({tag, " valid"}, {31'b0, eng_tx_valid}, 32'd1);
        chk({tag, " byte"}, {24'b0, eng_tx_byte}, {24'b0, exp});
        eng_tx_pop = 1'b1;
        tick();
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_byte = b;
        tick();
        eng_rx_push = 1'b0;
    endtask

    task automatic rx_read(input logic word);
        host_rx_rd = 1'b1; host_rx_word = word;
        tick();
        host_rx_rd = 1'b0;
    endtask

    task automatic rx_read_chk(input string tag, input logic word, input logic [31:0] exp);
        host_rx_rd = 1'b1; host_rx_word = word;
        #1;
        chk(tag, host_rx_rdata, exp);
        tick();
        host_rx_rd = 1'b0;
    endtask

    task automatic clr(input logic [12:0] m);
        irq_clr_wr = 1'b1; irq_clr_wdata = m;
        tick();
        irq_clr_wr = 1'b0;
    endtask

    task automatic en(input logic [12:0] m);
        irq_en_wr = 1'b1; irq_en_wdata = m;
        tick();
        irq_en_wr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 status in reset", {19'b0, irq_status}, 32'h0);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 tx valid in reset", {31'b0, eng_tx_valid}, 32'h0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R8 idle flags tx trig+empty", {19'b0, irq_status}, 32'h003);
    endtask

    task automatic t_tx_word_order();
        word_mode = 1'b1;
        tick();
        tx_write(1'b1, 32'hD4C3B2A1);
        pop_chk("R2 lane0", 8'hA1);
        pop_chk("R2 lane1", 8'hB2);
        pop_chk("R2 lane2", 8'hC3);
        pop_chk("R2 lane3", 8'hD4);
        chk("R2 drained", {31'b0, eng_tx_valid}, 32'h0);
        tx_write(1'b1, 32'h04030201);
        tx_write(1'b1, 32'h08070605);
        for (int i = 1; i <= 8; i++) pop_chk("R2 two words", 8'(i));
        chk("R2 drained again", {31'b0, eng_tx_valid}, 32'h0);
    endtask

    task automatic t_tx_byte_mode();
        word_mode = 1'b0;
        tick();
        tx_write(1'b0, 32'hFFFFFF5A);
        tx_write(1'b0, 32'hFFFFFF6B);
        tx_write(1'b0, 32'hFFFFFF7C);
        pop_chk("R3 byte fifo 1", 8'h5A);
        pop_chk("R3 byte fifo 2", 8'h6B);
        pop_chk("R3 byte fifo 3", 8'h7C);
        chk("R3 drained", {31'b0, eng_tx_valid}, 32'h0);
    endtask

    task automatic t_tx_overflow();
        word_mode = 1'b0;
        tick();
        clr(13'h1FFF);
        for (int i = 0; i < 7; i++) tx_write(1'b0, 32'(8'h10 + i));
        tick();
        chk("R8 tx half below 8", {31'b0, irq_status[2]}, 32'h0);
        tx_write(1'b0, 32'h17);
        tick();
        chk("R8 tx half at 8", {31'b0, irq_status[2]}, 32'h1);
        for (int i = 8; i < 16; i++) tx_write(1'b0, 32'(8'h10 + i));
        tick();
        chk("R3 full at 16 bytes", {31'b0, irq_status[3]}, 32'h1);
        chk("R5 no illegal yet", {31'b0, irq_status[12]}, 32'h0);
        tx_write(1'b0, 32'hEE);
        tick(); tick();
        chk("R5 byte overflow flagged", {31'b0, irq_status[12]}, 32'h1);
        chk("R9 illegal sticky", {31'b0, irq_status[12]}, 32'h1);
        clr(13'h1000);
        chk("R9 illegal cleared", {31'b0, irq_status[12]}, 32'h0);
        tx_write(1'b1, 32'hAAAAAAAA);
        chk("R5 word write lane0 full", {31'b0, irq_status[12]}, 32'h1);
        for (int i = 0; i < 16; i++) pop_chk("R5 overflow ignored", 8'(8'h10 + i));
        chk("R5 17th byte dropped", {31'b0, eng_tx_valid}, 32'h0);
        word_mode = 1'b1;
        tick();
        clr(13'h1FFF);
        tick();
        chk("R5 word write left lanes empty", {31'b0, irq_status[1]}, 32'h1);
    endtask

    task automatic t_word_capacity();
        word_mode = 1'b1;
        tick();
        clr(13'h1FFF);
        for (int i = 0; i < 7; i++) tx_write(1'b1, (i + 1) * 32'h01010101);
        tick();
        chk("R4 half below 32 bytes", {31'b0, irq_status[2]}, 32'h0);
        tx_write(1'b1, 8 * 32'h01010101);
        tick();
        chk("R4 half at 32 bytes", {31'b0, irq_status[2]}, 32'h1);
        chk("R4 not full at 32", {31'b0, irq_status[3]}, 32'h0);
        for (int i = 8; i < 16; i++) tx_write(1'b1, (i + 1) * 32'h01010101);
        tick();
        chk("R4 full at 64 bytes", {31'b0, irq_status[3]}, 32'h1);
        chk("R4 no illegal for 16 words", {31'b0, irq_status[12]}, 32'h0);
        tx_write(1'b1, 32'h99999999);
        chk("R5 17th word illegal", {31'b0, irq_status[12]}, 32'h1);
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++) pop_chk("R4 word drain", 8'(i + 1));
        chk("R4 drained", {31'b0, eng_tx_valid}, 32'h0);
    endtask

    task automatic t_rx_word();
        word_mode = 1'b1;
        tick();
        clr(13'h1FFF);
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        tick();
        chk("R6 word not avail at 3", {31'b0, irq_status[6]}, 32'h0);
        chk("R7 byte avail", {31'b0, irq_status[11]}, 32'h1);
        rx_read(1'b1);
        chk("R5 early word read illegal", {31'b0, irq_status[12]}, 32'h1);
        rx_push(8'h44);
        tick();
        chk("R6 word avail at 4", {31'b0, irq_status[6]}, 32'h1);
        rx_read_chk("R6 word read", 1'b1, 32'h44332211);
        clr(13'h1FFF);
        tick();
        chk("R6 rx empty after read", {20'b0, irq_status[11], 4'b0, irq_status[6], 6'b0}, 32'h0);
    endtask

    task automatic t_rx_byte();
        word_mode = 1'b0;
        tick();
        clr(13'h1FFF);
        for (int i = 0; i < 7; i++) rx_push(8'(8'h40 + i));
        tick();
        chk("R8 rx trig below 8", {31'b0, irq_status[5]}, 32'h0);
        chk("R8 rx half below 8", {31'b0, irq_status[7]}, 32'h0);
        rx_push(8'h47);
        tick();
        chk("R8 rx trig at 8", {31'b0, irq_status[5]}, 32'h1);
        chk("R8 rx half at 8", {31'b0, irq_status[7]}, 32'h1);
        for (int i = 8; i < 16; i++) rx_push(8'(8'h40 + i));
        tick();
        chk("R8 rx full at 16", {31'b0, irq_status[8]}, 32'h1);
        chk("R8 rx not ready", {31'b0, eng_rx_ready}, 32'h0);
        for (int i = 0; i < 16; i++) rx_read_chk("R7 byte read", 1'b0, 32'(8'h40 + i));
        clr(13'h1000);
        rx_read(1'b0);
        chk("R5 empty byte read illegal", {31'b0, irq_status[12]}, 32'h1);
        clr(13'h1FFF);
        tick();
        chk("R7 byte avail low", {31'b0, irq_status[11]}, 32'h0);
    endtask

    task automatic t_clear_relevel();
        word_mode = 1'b0;
        tick();
        clr(13'h1FFF);
        chk("R9 cleared next edge", {19'b0, irq_status}, 32'h0);
        tick();
        chk("R9 level flags return", {19'b0, irq_status}, 32'h003);
    endtask

    task automatic t_done();
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        chk("R10 done latched", {31'b0, irq_status[9]}, 32'h1);
        tick(); tick();
        chk("R10 done held", {31'b0, irq_status[9]}, 32'h1);
        clr(13'h0200);
        tick(); tick();
        chk("R10 done stays clear", {31'b0, irq_status[9]}, 32'h0);
    endtask

    task automatic t_irq();
        clr(13'h1FFF);
        en(13'h1000);
        tick();
        chk("R11 masked flags no irq", {31'b0, irq}, 32'h0);
        rx_read(1'b0);
        chk("R11 irq on illegal", {31'b0, irq}, 32'h1);
        clr(13'h1000);
        chk("R11 irq drops on clear", {31'b0, irq}, 32'h0);
        en(13'h0002);
        chk("R11 irq from empty flag", {31'b0, irq}, 32'h1);
        en(13'h0000);
        chk("R11 irq off when disabled", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_tx_word_order();
        t_tx_byte_mode();
        t_tx_overflow();
        t_word_capacity();
        t_rx_word();
        t_rx_byte();
        t_clear_relevel();
        t_done();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule